// File: doc/BRIEF.md
# Three-Regime Switching Period Generator

This block produces the switching timing for a peak-current-mode power stage. It opens a new switching period with a gate-on request. It ends the on-time on a current-sense trip, on a programmable minimum on-time, or on a maximum-duty cap. It also raises a blanking window during which the current-sense trip is disregarded. A one-cycle strobe marks the start of every period.

The period length comes from one of three regimes, picked from a 3-bit level code. The code is supplied by external comparators watching the compensation voltage.

- **Normal:** a fixed period with triangular jitter.
- **Burst:** a long period that sets the frequency floor.
- **Green:** a very long period for no-load operation.

The regime changes with hysteresis, and the period is latched at each period start.

Top module: `pwm_mode_timer`

## Requirements
- R1: While `rst_n` is low, `gate`, `blank` and `cyc_start` are 0. After release, the first period is a normal-regime period with zero jitter offset.
- R2: In the normal regime the period is `PER_NORM + j*JIT_STEP` clock cycles, where `j` is the jitter offset in effect at the period start.
- R3: The jitter offset starts at 0 and rises first. It moves by one at every normal-regime period start. It turns around on reaching `+JIT_MAX` or `-JIT_MAX`, and it holds its value while the block is in another regime.
- R4: `comp_zone` is a thermometer code: bit 0 set means above the green threshold, bit 1 set means above the burst-exit level, and bit 2 set means above the burst-entry level. From normal, the block moves to the burst regime (period `PER_BURST`) when bit 2 is clear and bit 0 is set. From burst or green, it returns to normal when bit 2 is set.
- R5: The block enters the green regime (period `PER_GREEN`) from normal or burst when bit 0 is clear. It leaves green for burst only when bit 1 is set, so code 001 keeps whichever of burst or green is already active.
- R6: The regime in effect when a period starts fixes that period's length. A code change during a period takes effect from the next period.
- R7: The on-time never exceeds floor(period*`DMAX_PCT`/100) cycles. With no trip, `gate` stays high for exactly that many cycles.
- R8: `blank` is high for the first `LEB_CYC` cycles of each on-time, and a `cs_trip` during those cycles has no effect.
- R9: A `cs_trip` seen in cycle k of the on-time (k counted from 0 at the period start, with k at least `LEB_CYC`) drops `gate` so that the on-time is k+1 cycles. This holds when `min_on` is at most k+1.
- R10: If the first effective trip comes before `min_on` cycles of on-time have elapsed, `gate` drops after exactly `min_on` cycles. The maximum-duty cap of R7 still takes precedence.
- R11: `cyc_start` is a one-cycle pulse in the first cycle of every period, and `gate` rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_zone | input | 3 | Thermometer level code of the compensation voltage |
| cs_trip | input | 1 | Peak-current comparator output |
| min_on | input | MTW | Minimum on-time in clock cycles |
| gate | output | 1 | Gate-on request |
| blank | output | 1 | Leading-edge blanking window |
| cyc_start | output | 1 | Strobe in the first cycle of each period |

## Verification
A wrong regime or a corrupted jitter offset shows up as a wrong spacing between two `cyc_start` pulses. That spacing is visible at the very next period start, so the bench measures the length of every period and compares it with its own model of regime and offset. A fault in the on-time logic shows up within the same period as a wrong count of `gate`-high cycles. The bench drives trips inside the blanking window, just after it ends, before the minimum on-time, and beyond the duty cap. Hysteresis faults appear one period after a level-code change, so the stimulus table holds the same code across consecutive periods and checks that the regime does not move.

// File: rtl/pwm_mode_timer.sv
module pwm_mode_timer #(
  parameter int PER_NORM  = 1538,
  parameter int PER_BURST = 100000,
  parameter int PER_GREEN = 400000,
  parameter int JIT_STEP  = 1,
  parameter int JIT_MAX   = 92,
  parameter int DMAX_PCT  = 77,
  parameter int LEB_CYC   = 38,
  parameter int MTW       = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     comp_zone,
  input  logic           cs_trip,
  input  logic [MTW-1:0] min_on,
  output logic           gate,
  output logic           blank,
  output logic           cyc_start
);
  localparam int CW = $clog2(PER_GREEN + PER_NORM + JIT_MAX * JIT_STEP + 1);
  localparam int JW = $clog2(JIT_MAX + 1) + 1;
  localparam logic signed [JW-1:0] JHI = JW'(JIT_MAX);
  localparam logic signed [JW-1:0] JLO = -JHI;

  typedef enum logic [1:0] {M_NORM, M_BURST, M_GREEN} mode_t;

  mode_t mode_q, mode_d;
  logic [CW-1:0] cnt_q, per_q, dmax_q, per_nx, dmax_nx, cnt_p1;
  logic signed [JW-1:0] jit_q;
  logic jdn_q, gate_q, pend_q, cyc_q;
  logic wrap, trip_ok, min_ok, dmax_hit;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_NORM:  if (!comp_zone[0]) mode_d = M_GREEN;
               else if (!comp_zone[2]) mode_d = M_BURST;
      M_BURST: if (comp_zone[2]) mode_d = M_NORM;
               else if (!comp_zone[0]) mode_d = M_GREEN;
      default: if (comp_zone[2]) mode_d = M_NORM;
               else if (comp_zone[1]) mode_d = M_BURST;
    endcase
  end

  always_comb begin
    case (mode_q)
      M_NORM:  per_nx = CW'(PER_NORM + int'(jit_q) * JIT_STEP);
      M_BURST: per_nx = CW'(PER_BURST);
      default: per_nx = CW'(PER_GREEN);
    endcase
  end

  assign dmax_nx  = CW'((int'(per_nx) * DMAX_PCT) / 100);
  assign cnt_p1   = cnt_q + CW'(1);
  assign wrap     = (cnt_q == per_q - CW'(1));
  assign blank    = gate_q && (cnt_q < CW'(LEB_CYC));
  assign trip_ok  = cs_trip && gate_q && !blank;
  assign min_ok   = 32'(cnt_p1) >= 32'(min_on);
  assign dmax_hit = cnt_p1 >= dmax_q;
  assign gate      = gate_q;
  assign cyc_start = cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_NORM;
      cnt_q  <= '0;
      per_q  <= CW'(1);
      dmax_q <= '0;
      gate_q <= 1'b0;
      pend_q <= 1'b0;
      cyc_q  <= 1'b0;
      jit_q  <= '0;
      jdn_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cyc_q  <= wrap;
      if (wrap) begin
        cnt_q  <= '0;
        per_q  <= per_nx;
        dmax_q <= dmax_nx;
        gate_q <= 1'b1;
        pend_q <= 1'b0;
        if (mode_q == M_NORM) begin
          if (!jdn_q) begin
            if (jit_q == JHI) begin
              jdn_q <= 1'b1;
              jit_q <= jit_q - JW'(1);
            end else jit_q <= jit_q + JW'(1);
          end else begin
            if (jit_q == JLO) begin
              jdn_q <= 1'b0;
              jit_q <= jit_q + JW'(1);
            end else jit_q <= jit_q - JW'(1);
          end
        end
      end else begin
        cnt_q <= cnt_p1;
        if (gate_q) begin
          if (dmax_hit || ((trip_ok || pend_q) && min_ok)) gate_q <= 1'b0;
          else if (trip_ok) pend_q <= 1'b1;
        end
      end
    end
  end
endmodule

module pwm_mode_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic gate,
  input logic blank,
  input logic cyc_start,
  input logic cs_trip
);
  a_r8_blank_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> gate);
  a_r8_blank_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> blank);
  a_r8_trip_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && cs_trip) |=> gate);
  a_r11_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> cyc_start);
  a_r11_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> gate);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);
endmodule

bind pwm_mode_timer pwm_mode_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .blank(blank),
  .cyc_start(cyc_start), .cs_trip(cs_trip)
);

// File: tb/pwm_mode_timer_test.sv
module pwm_mode_timer_test;
  localparam int LEB = 4;
  localparam int NROW = 18;
  // {zone[2:0], min_on[7:0], trip_at[8:0] (511 = none), exp_period[9:0], exp_on[9:0]}
  localparam logic [39:0] TBL [NROW] = '{
    {3'b111, 8'd3,  9'd511, 10'd100, 10'd77},  // R1 R2 R7 first period, offset 0
    {3'b111, 8'd3,  9'd10,  10'd102, 10'd11},  // R3 R9
    {3'b111, 8'd3,  9'd1,   10'd104, 10'd5},   // R8 trip inside blanking
    {3'b111, 8'd20, 9'd6,   10'd106, 10'd20},  // R10 offset peak
    {3'b111, 8'd90, 9'd511, 10'd104, 10'd80},  // R3 turn-around, R7 over R10
    {3'b011, 8'd3,  9'd30,  10'd102, 10'd31},  // R6 code change applies next period
    {3'b001, 8'd3,  9'd8,   10'd200, 10'd9},   // R4 burst
    {3'b000, 8'd3,  9'd511, 10'd200, 10'd154}, // R5 burst held on 001
    {3'b001, 8'd60, 9'd50,  10'd400, 10'd60},  // R5 green, R10
    {3'b011, 8'd3,  9'd2,   10'd400, 10'd5},   // R5 green held on 001
    {3'b111, 8'd0,  9'd3,   10'd200, 10'd5},   // R5 exit to burst
    {3'b111, 8'd3,  9'd0,   10'd100, 10'd5},   // R4 back to normal, R3 offset held
    {3'b111, 8'd3,  9'd511, 10'd98,  10'd75},
    {3'b111, 8'd3,  9'd511, 10'd96,  10'd73},
    {3'b111, 8'd3,  9'd511, 10'd94,  10'd72},  // R3 lower bound
    {3'b111, 8'd5,  9'd4,   10'd96,  10'd5},   // R9 trip at blank end
    {3'b000, 8'd3,  9'd511, 10'd98,  10'd75},
    {3'b111, 8'd3,  9'd511, 10'd400, 10'd308}  // R5 normal straight to green
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_trip = 1'b0;
  logic [2:0] comp_zone = 3'b111;
  logic [15:0] min_on = 16'd3;
  logic gate, blank, cyc_start;
  int checks = 0, errors = 0, trip_at = 511;
  int m_per, m_on, m_blk, m_cyc;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_mode_timer #(.PER_NORM(100), .PER_BURST(200), .PER_GREEN(400), .JIT_STEP(2),
    .JIT_MAX(3), .DMAX_PCT(77), .LEB_CYC(LEB), .MTW(16)) uut (
    .clk(clk), .rst_n(rst_n), .comp_zone(comp_zone), .cs_trip(cs_trip),
    .min_on(min_on), .gate(gate), .blank(blank), .cyc_start(cyc_start));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic [2:0] z, input int mo, input int tr);
    int i;
    while (!cyc_start) @(negedge clk);
    comp_zone = z; min_on = 16'(mo); trip_at = tr;
    m_on = 0; m_blk = 0; m_cyc = 0; i = 0;
    forever begin
      cs_trip = (i >= trip_at);
      if (gate) m_on++;
      if (blank) m_blk++;
      if (cyc_start) m_cyc++;
      @(negedge clk);
      i++;
      if (cyc_start) break;
    end
    m_per = i;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 gate in reset", gate, 0);
    check("R1 blank in reset", blank, 0);
    check("R1 strobe in reset", cyc_start, 0);
    rst_n = 1'b1;
    for (int r = 0; r < NROW; r++) begin
      logic [39:0] v;
      v = TBL[r];
      measure(v[39:37], int'(v[36:29]), int'(v[28:20]));
      check($sformatf("R2/R4/R5/R6 period row %0d", r), m_per, int'(v[19:10]));
      check($sformatf("R7/R9/R10 on-time row %0d", r), m_on, int'(v[9:0]));
      check($sformatf("R8 blank length row %0d", r), m_blk, (LEB < m_on) ? LEB : m_on);
      check($sformatf("R11 strobe count row %0d", r), m_cyc, 1);
    end
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 gate on mid-run reset", gate, 0);
    check("R1 blank on mid-run reset", blank, 0);
    check("R1 strobe on mid-run reset", cyc_start, 0);
    comp_zone = 3'b000;
    @(negedge clk);
    comp_zone = 3'b111;
    @(negedge clk);
    rst_n = 1'b1;
    measure(3'b111, 3, 511);
    check("R1 period after reset", m_per, 100);
    check("R1 on-time after reset", m_on, 77);
    finish_run();
  end
endmodule